// File: doc/BRIEF.md
# Snoop Outcome Resolver for In-Flight Miss and Writeback State

A cache that tracks outstanding misses in a miss table and holds evicted dirty lines in a writeback buffer cannot always answer a bus snoop from its tag array alone. This block decides the outcome of each incoming snoop from that in-flight state. It takes the snoop command, the word index of the snooped address within the line, an uncacheable flag, and the lookup results the surrounding cache has already produced for the same line in the miss table and the writeback buffer.

One cycle after a snoop is presented, the block raises one registered outcome. A NACK tells the requester to retry. An append request tells the miss table to queue an invalidate behind its pending fill. A writeback-buffer action either supplies the buffered word, marked as shared, or marks the buffered entry as in service. A pass-through hands the snoop to the normal tag and coherence path, which lies outside this block. Uncacheable snoops produce no outcome at all.

Top module: `snp_resolver`

## Requirements
- R1: A snoop with `snp_uncache` high raises none of the outputs in the following cycle, whatever the lookup inputs are.
- R2: If the miss table hits an in-service entry whose request is invalidating (`mt_req_inval`) or is not a line fill (`mt_req_fill` low), the snoop is NACKed: `o_nack` and `o_satisfied` are high. This applies to snoop commands 2'b00 (read) and 2'b11 (read-for-ownership).
- R3: A snoop that hits an in-service miss entry and does not meet the R2 condition raises only `o_append_inval`. Commands 2'b01 (invalidate) and 2'b10 (write-invalidate) always take this path on an in-service hit.
- R4: An in-service miss-table hit decides the outcome even when the writeback buffer also hits.
- R5: A reading snoop (command 2'b00 or 2'b11) that hits a cacheable writeback entry raises `o_wb_taken`, `o_satisfied`, `o_shared` and `o_supply`.
- R6: An invalidating snoop (command 2'b01, 2'b10 or 2'b11) that hits a cacheable writeback entry raises `o_wb_taken` and `o_wb_mark`. Command 2'b01 or 2'b10 alone does not raise `o_satisfied`.
- R7: While `o_supply` is high, `o_data` carries the word of `wb_line` selected by `snp_word`, where word k occupies bits [k*WORD_W +: WORD_W]. Otherwise `o_data` is zero.
- R8: A miss-table hit whose entry is not in service does not affect the outcome.
- R9: A cacheable snoop that meets none of R2, R3, R5 or R6 raises only `o_pass`. This includes a writeback hit on an uncacheable entry (`wb_cacheable` low).
- R10: For every cacheable snoop, exactly one of `o_nack`, `o_append_inval`, `o_wb_taken` and `o_pass` is high in the next cycle. All outputs are zero in a cycle that follows no snoop.
- R11: Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | A snoop is presented this cycle |
| snp_cmd | input | 2 | 00 read, 01 invalidate, 10 write-invalidate, 11 read-for-ownership |
| snp_word | input | IDX_W | Word index of the snooped address within the line |
| snp_uncache | input | 1 | Snoop targets an uncacheable address |
| mt_hit | input | 1 | Miss table holds an entry for the snooped line |
| mt_in_service | input | 1 | That miss entry has been issued to the bus |
| mt_req_inval | input | 1 | The outstanding request is invalidating |
| mt_req_fill | input | 1 | The outstanding request is a line fill |
| wb_hit | input | 1 | Writeback buffer holds the snooped line |
| wb_cacheable | input | 1 | That writeback entry is cacheable |
| wb_line | input | LINE_W | Data of the buffered line |
| o_nack | output | 1 | Snoop refused, requester must retry |
| o_satisfied | output | 1 | Snoop answered by this cache |
| o_shared | output | 1 | Line reported as shared |
| o_supply | output | 1 | `o_data` is valid |
| o_data | output | WORD_W | Supplied word |
| o_append_inval | output | 1 | Queue an invalidate on the miss entry |
| o_wb_taken | output | 1 | Writeback buffer handled the snoop |
| o_wb_mark | output | 1 | Mark the writeback entry in service |
| o_pass | output | 1 | Forward the snoop to the tag path |

## Verification
A wrong priority between the miss table and the writeback buffer shows as the wrong outcome strobe in the cycle right after the snoop. For example, a snoop on a line that is filling would supply stale buffered data instead of appending an invalidate. A wrong command decode shows as a NACK on an invalidating snoop, or as a mark without a supply on a read-for-ownership. A wrong word select shows only in `o_data` during the supply cycle, so every word index at the edges of the line is exercised. Because outcomes are single-cycle pulses, leaked or stuck state shows up as a nonzero output in an idle cycle.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    SNP_RD   = 2'b00,
    SNP_INV  = 2'b01,
    SNP_WINV = 2'b10,
    SNP_RFO  = 2'b11
  } snp_cmd_e;

  typedef struct packed {
    logic nack;
    logic sat;
    logic shared;
    logic supply;
    logic append;
    logic wb_take;
    logic wb_mark;
    logic pass;
  } snp_out_t;

  function automatic logic cmd_reads(snp_cmd_e c);
    return (c == SNP_RD) || (c == SNP_RFO);
  endfunction

  function automatic logic cmd_invals(snp_cmd_e c);
    return c != SNP_RD;
  endfunction

  // commands that may never be refused by an in-flight miss
  function automatic logic cmd_no_nack(snp_cmd_e c);
    return (c == SNP_INV) || (c == SNP_WINV);
  endfunction

endpackage

// File: rtl/snp_word_pick.sv
module snp_word_pick #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic [LINE_W-1:0] line,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] lanes [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign lanes[g] = line[g*WORD_W +: WORD_W];
  end

  assign word = lanes[idx];
endmodule

// File: rtl/snp_classify.sv
module snp_classify
  import snp_pkg::*;
(
  input  logic     valid,
  input  snp_cmd_e cmd,
  input  logic     uncache,
  input  logic     mt_hit,
  input  logic     mt_svc,
  input  logic     mt_inval,
  input  logic     mt_fill,
  input  logic     wb_hit,
  input  logic     wb_cache,
  output snp_out_t res
);
  logic refuse;
  assign refuse = (mt_inval || !mt_fill) && !cmd_no_nack(cmd);

  always_comb begin
    res = '0;
    if (valid && !uncache) begin
      if (mt_hit && mt_svc) begin
        if (refuse) begin
          res.nack = 1'b1;
          res.sat  = 1'b1;
        end else begin
          res.append = 1'b1;
        end
      end else if (wb_hit && wb_cache) begin
        res.wb_take = 1'b1;
        if (cmd_reads(cmd)) begin
          res.sat    = 1'b1;
          res.shared = 1'b1;
          res.supply = 1'b1;
        end
        if (cmd_invals(cmd)) res.wb_mark = 1'b1;
      end else begin
        res.pass = 1'b1;
      end
    end
  end
endmodule

// File: rtl/snp_resolver.sv
module snp_resolver
  import snp_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int WORDS  = LINE_BYTES / WORD_BYTES,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [IDX_W-1:0]  snp_word,
  input  logic              snp_uncache,
  input  logic              mt_hit,
  input  logic              mt_in_service,
  input  logic              mt_req_inval,
  input  logic              mt_req_fill,
  input  logic              wb_hit,
  input  logic              wb_cacheable,
  input  logic [LINE_W-1:0] wb_line,
  output logic              o_nack,
  output logic              o_satisfied,
  output logic              o_shared,
  output logic              o_supply,
  output logic [WORD_W-1:0] o_data,
  output logic              o_append_inval,
  output logic              o_wb_taken,
  output logic              o_wb_mark,
  output logic              o_pass
);
  snp_out_t          res_d, res_q;
  logic [WORD_W-1:0] word_d, data_q;

  snp_classify u_cls (
    .valid    (snp_valid),
    .cmd      (snp_cmd_e'(snp_cmd)),
    .uncache  (snp_uncache),
    .mt_hit   (mt_hit),
    .mt_svc   (mt_in_service),
    .mt_inval (mt_req_inval),
    .mt_fill  (mt_req_fill),
    .wb_hit   (wb_hit),
    .wb_cache (wb_cacheable),
    .res      (res_d)
  );

  snp_word_pick #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pick (
    .line (wb_line),
    .idx  (snp_word),
    .word (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      data_q <= '0;
    end else begin
      res_q  <= res_d;
      data_q <= res_d.supply ? word_d : '0;
    end
  end

  assign o_nack         = res_q.nack;
  assign o_satisfied    = res_q.sat;
  assign o_shared       = res_q.shared;
  assign o_supply       = res_q.supply;
  assign o_data         = data_q;
  assign o_append_inval = res_q.append;
  assign o_wb_taken     = res_q.wb_take;
  assign o_wb_mark      = res_q.wb_mark;
  assign o_pass         = res_q.pass;
endmodule

// File: rtl/snp_resolver_chk.sv
module snp_resolver_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_uncache,
  input logic              o_nack,
  input logic              o_satisfied,
  input logic              o_shared,
  input logic              o_supply,
  input logic [WORD_W-1:0] o_data,
  input logic              o_append_inval,
  input logic              o_wb_taken,
  input logic              o_wb_mark,
  input logic              o_pass
);
  logic [3:0] outcome;
  assign outcome = {o_nack, o_append_inval, o_wb_taken, o_pass};

  p_uncache_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_uncache) |=> (outcome == 4'b0 && !o_satisfied));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !snp_uncache) |=> $onehot(outcome));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !snp_valid |=> (outcome == 4'b0 && !o_satisfied && o_data == '0));

  p_nack_answers_r2: assert property (@(posedge clk) disable iff (rst)
    o_nack |-> o_satisfied);

  p_exempt_no_nack_r3: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && (snp_cmd == 2'b01 || snp_cmd == 2'b10)) |=> !o_nack);

  p_supply_shared_r5: assert property (@(posedge clk) disable iff (rst)
    o_supply |-> (o_shared && o_satisfied && o_wb_taken));

  p_mark_from_wb_r6: assert property (@(posedge clk) disable iff (rst)
    o_wb_mark |-> o_wb_taken);
endmodule

bind snp_resolver snp_resolver_chk #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .snp_valid      (snp_valid),
  .snp_cmd        (snp_cmd),
  .snp_uncache    (snp_uncache),
  .o_nack         (o_nack),
  .o_satisfied    (o_satisfied),
  .o_shared       (o_shared),
  .o_supply       (o_supply),
  .o_data         (o_data),
  .o_append_inval (o_append_inval),
  .o_wb_taken     (o_wb_taken),
  .o_wb_mark      (o_wb_mark),
  .o_pass         (o_pass)
);

// File: tb/snp_resolver_tb_top.sv
`timescale 1ns/1ps
module snp_resolver_tb_top;
  localparam int WORD_W = 32;
  localparam int WORDS  = 8;
  localparam int LINE_W = WORD_W * WORDS;
  localparam int NV     = 15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst, snp_valid, snp_uncache;
  logic [1:0]        snp_cmd;
  logic [2:0]        snp_word;
  logic              mt_hit, mt_in_service, mt_req_inval, mt_req_fill;
  logic              wb_hit, wb_cacheable;
  logic [LINE_W-1:0] wb_line;
  logic              o_nack, o_satisfied, o_shared, o_supply;
  logic [WORD_W-1:0] o_data;
  logic              o_append_inval, o_wb_taken, o_wb_mark, o_pass;

  snp_resolver dut_i (.*);

  int checks = 0;
  int fails  = 0;

  // {cmd, unc mh ms mi mf wh wc, word, nack sat shr sup app wbt mark pass}
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 7'b1111011, 3'd0, 8'b00000000},  // R1
    {2'd1, 7'b1000011, 3'd0, 8'b00000000},  // R1
    {2'd0, 7'b0111100, 3'd0, 8'b11000000},  // R2 invalidating fill
    {2'd3, 7'b0110000, 3'd0, 8'b11000000},  // R2 not a fill
    {2'd1, 7'b0111000, 3'd0, 8'b00001000},  // R3
    {2'd2, 7'b0110000, 3'd0, 8'b00001000},  // R3
    {2'd0, 7'b0110100, 3'd0, 8'b00001000},  // R3 plain fill
    {2'd0, 7'b0110111, 3'd2, 8'b00001000},  // R4
    {2'd0, 7'b0000011, 3'd5, 8'b01110100},  // R5
    {2'd1, 7'b0000011, 3'd1, 8'b00000110},  // R6
    {2'd3, 7'b0000011, 3'd7, 8'b01110110},  // R6 with R5
    {2'd0, 7'b0101011, 3'd0, 8'b01110100},  // R8
    {2'd0, 7'b0000010, 3'd4, 8'b00000001},  // R9
    {2'd1, 7'b0000000, 3'd0, 8'b00000001},  // R9
    {2'd2, 7'b0100000, 3'd0, 8'b00000001}   // R8
  };
  localparam int VREQ [NV] = '{1, 1, 2, 2, 3, 3, 3, 4, 5, 6, 6, 8, 9, 9, 8};

  function automatic logic [LINE_W-1:0] mk_line(logic [15:0] seed);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < WORDS; i++)
      l[i*WORD_W +: WORD_W] = {seed, 16'(i * 16'h0101)};
    return l;
  endfunction

  function automatic logic [7:0] outs();
    return {o_nack, o_satisfied, o_shared, o_supply,
            o_append_inval, o_wb_taken, o_wb_mark, o_pass};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [19:0] v);
    snp_cmd       = v[19:18];
    snp_uncache   = v[17];
    mt_hit        = v[16];
    mt_in_service = v[15];
    mt_req_inval  = v[14];
    mt_req_fill   = v[13];
    wb_hit        = v[12];
    wb_cacheable  = v[11];
    snp_word      = v[10:8];
    snp_valid     = 1'b1;
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; snp_valid = 1'b0;
    apply(20'h0); snp_valid = 1'b0;
    wb_line = mk_line(16'hC0DE);
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {24'h0, outs()}, 32'h0);
    check("R11 reset data", o_data, 32'h0);
    rst = 1'b0;

    for (int n = 0; n < NV; n++) begin
      logic [31:0] exp_data;
      @(negedge clk);
      wb_line = mk_line(16'(16'hA000 + n));
      apply(VEC[n]);
      exp_data = VEC[n][4] ? {16'(16'hA000 + n), 16'(VEC[n][10:8] * 16'h0101)} : 32'h0;
      @(negedge clk);
      check($sformatf("R%0d vector %0d outcome", VREQ[n], n), {24'h0, outs()}, {24'h0, VEC[n][7:0]});
      check($sformatf("R7 vector %0d data", n), o_data, exp_data);
      snp_valid = 1'b0;
    end

    // R10 idle cycle after a snoop is quiet
    @(negedge clk);
    check("R10 idle outputs", {24'h0, outs()}, 32'h0);

    // R7 back-to-back supplies at both line ends, R10 no gap needed
    wb_line = mk_line(16'h5EED);
    apply({2'd0, 7'b0000011, 3'd0, 8'h0});
    @(negedge clk);
    check("R7 word 0", o_data, 32'h5EED_0000);
    apply({2'd3, 7'b0000011, 3'd7, 8'h0});
    @(negedge clk);
    check("R7 word 7", o_data, 32'h5EED_0707);
    check("R10 rfo outcome", {24'h0, outs()}, 32'h76);
    apply({2'd2, 7'b0000000, 3'd0, 8'h0});
    @(negedge clk);
    check("R10 pass after supply", {24'h0, outs()}, 32'h01);
    check("R7 data cleared", o_data, 32'h0);

    // R11 reset overrides a pending snoop
    apply({2'd0, 7'b0000011, 3'd3, 8'h0});
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset over snoop", {24'h0, outs()}, 32'h0);
    check("R11 reset data", o_data, 32'h0);
    rst = 1'b0; snp_valid = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule